// File: doc/BRIEF.md
# Trace-Signature Last-Touch Predictor

This block sits beside a node's cache controller in a distributed shared-memory machine. It watches every load and store that hits an actively shared cache block. From the coherence miss that brought a block in until the block is invalidated, it keeps a compact running signature of the instructions that touched it. When an invalidation ends such a trace, the signature is learned as a "last-touch" pattern for that block. When a later trace on the same block reaches a learned pattern that is trusted enough, the block raises a self-invalidate request. The controller can then give the block up before another node asks for it.

Each block owns a private table of learned signatures, so patterns from one block never affect another. Every stored signature carries a small saturating confidence counter. Learning and directory feedback move that counter, and only a fully saturated entry may trigger a request. Each block also has a two-state trace tracker. `TR_CLOSED` means no trace is open and non-miss accesses are ignored. `TR_OPEN` means a signature is being accumulated. A coherence miss moves the tracker from `TR_CLOSED` to `TR_OPEN`. In `TR_OPEN`, a coherence miss restarts the trace. An invalidation or an issued self-invalidation moves the tracker back to `TR_CLOSED`.

Top module: `lt_predictor`

## Requirements
- R1: After reset, no self-invalidate is requested, every trace is closed and every signature table is empty.
- R2: A coherence-miss access to an actively shared block loads that block's 13-bit signature with the low 13 bits of the access PC and opens (or restarts) its trace. A miss access never produces a request.
- R3: A non-miss access to a block with an open trace replaces the signature with (signature + PC) modulo 2^13, so carries above bit 12 are discarded.
- R4: An invalidation for a block with an open trace closes the trace and learns its signature. A signature not yet stored is written with confidence 2. A signature already stored has its confidence raised by one, saturating at 3.
- R5: A non-miss access predicts a last touch only if its updated signature equals a stored signature of the same block whose confidence is 3. An empty table, or a signature learned only in another block, never predicts.
- R6: A prediction drives `selfinv_valid` high for exactly one cycle, in the cycle after the access, with `selfinv_block` equal to the accessed block index. The block's trace is then closed.
- R7: An access with `acc_shared` low, or a non-miss access to a block whose trace is closed, changes no state and produces no request.
- R8: Feedback for a block adjusts the confidence of the entry that issued that block's most recent request. `fb_correct`=1 raises it (saturating at 3). `fb_correct`=0 lowers it (saturating at 0). The record is then cleared, so further feedback without a new request is ignored.
- R9: Each block's table has 4 entries. A new signature replaces entries in round-robin order, so the oldest insertion is replaced first. The pointer advances only on new insertions, not on confidence increments.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | A memory access is presented this cycle |
| acc_block | input | 3 | Block index of the access |
| acc_pc | input | 30 | PC of the accessing instruction |
| acc_miss | input | 1 | The access took a coherence miss |
| acc_shared | input | 1 | The block is marked actively shared |
| inv_valid | input | 1 | An invalidation arrived this cycle |
| inv_block | input | 3 | Block index of the invalidation |
| fb_valid | input | 1 | Directory feedback on an earlier self-invalidation |
| fb_block | input | 3 | Block index the feedback refers to |
| fb_correct | input | 1 | 1 = self-invalidation was timely, 0 = premature |
| selfinv_valid | output | 1 | One-cycle self-invalidate request |
| selfinv_block | output | 3 | Block index of the request |

## Verification
The bench trains a block and checks that the first repetition stays silent and that the third trace fires. A design that initialised confidence at saturation, or that counted a mere match, would fire one trace too early. A signature that wraps past 2^13 must match a trace built from different PCs with the same low bits. A design that kept carries would never fire on that trace. A non-shared access inserted mid-trace, and touches after a request has closed the trace, must leave the signature alone. A design that accumulated them would miss the match or fire twice. For feedback and replacement, a double premature report must cost only one step. After five insertions the oldest pattern must be gone while the second survives. A wrong pointer or an uncleared feedback record shows up as a missing or extra request.

// File: rtl/ltp_pkg.sv
package ltp_pkg;

    // Per-block trace tracker states
    typedef enum logic [0:0] {
        TR_CLOSED = 1'b0,   // no coherence-miss trace in progress
        TR_OPEN   = 1'b1    // signature is being accumulated
    } trace_state_e;

    // Table update chosen in a cycle (learning has priority over feedback)
    typedef enum logic [1:0] {
        TBL_IDLE  = 2'd0,
        TBL_LEARN = 2'd1,
        TBL_FB    = 2'd2
    } tbl_op_e;

endpackage

// File: rtl/ltp_trace.sv
module ltp_trace
    import ltp_pkg::*;
#(
    parameter int PC_W  = 30,
    parameter int SIG_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_miss,    // coherence miss to this block
    input  logic             ev_touch,   // non-miss access to this block
    input  logic             ev_close,   // invalidation or issued request
    input  logic [PC_W-1:0]  pc,
    output logic             is_open,
    output logic [SIG_W-1:0] sig_q,
    output logic [SIG_W-1:0] sig_upd
);

    trace_state_e     state_q, state_d;
    logic [SIG_W-1:0] sig_d;
    logic [SIG_W-1:0] pc_sig;

    // truncated encodings of the PC and of the running sum
    assign pc_sig  = SIG_W'(pc);
    assign sig_upd = SIG_W'(sig_q + pc_sig);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TR_CLOSED;
            sig_q   <= '0;
        end else begin
            state_q <= state_d;
            sig_q   <= sig_d;
        end
    end

    // next state and signature
    always_comb begin
        state_d = state_q;
        sig_d   = sig_q;
        unique case (state_q)
            TR_CLOSED: begin
                if (ev_miss) begin
                    state_d = TR_OPEN;
                    sig_d   = pc_sig;
                end
            end
            TR_OPEN: begin
                if (ev_close) begin
                    state_d = TR_CLOSED;
                end else if (ev_miss) begin
                    sig_d = pc_sig;
                end else if (ev_touch) begin
                    sig_d = sig_upd;
                end
            end
            default: state_d = TR_CLOSED;
        endcase
    end

    // outputs
    always_comb begin
        is_open = (state_q == TR_OPEN);
    end

endmodule

// File: rtl/ltp_sig_table.sv
module ltp_sig_table
    import ltp_pkg::*;
#(
    parameter int SIG_W   = 13,
    parameter int ENTRIES = 4,
    parameter int CONF_W  = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [SIG_W-1:0]             probe_sig,
    input  logic                         learn_en,
    input  logic [SIG_W-1:0]             learn_sig,
    input  logic                         fb_en,
    input  logic                         fb_correct,
    input  logic                         issue_en,
    output logic                         hit_sat,
    output logic [$clog2(ENTRIES)-1:0]   hit_idx
);

    localparam int IDX_W = $clog2(ENTRIES);
    localparam logic [CONF_W-1:0] CONF_MAX  = {CONF_W{1'b1}};
    localparam logic [CONF_W-1:0] CONF_INIT = CONF_W'(1) << (CONF_W - 1);
    localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(ENTRIES - 1);

    logic [SIG_W-1:0]  sig_mem  [ENTRIES];
    logic [CONF_W-1:0] conf_mem [ENTRIES];
    logic [ENTRIES-1:0] vld_q;
    logic [IDX_W-1:0]  rr_q;
    logic [IDX_W-1:0]  last_idx_q;
    logic              last_vld_q;

    logic [ENTRIES-1:0] probe_match;
    logic [ENTRIES-1:0] learn_match;
    logic               learn_found;
    logic [IDX_W-1:0]   learn_idx;
    tbl_op_e            op;

    // one comparator pair per entry
    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
        assign probe_match[e] = vld_q[e] && (sig_mem[e] == probe_sig);
        assign learn_match[e] = vld_q[e] && (sig_mem[e] == learn_sig);
    end

    // saturated-match lookup (signatures are unique within a table)
    always_comb begin
        hit_sat = 1'b0;
        hit_idx = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (probe_match[e] && (conf_mem[e] == CONF_MAX)) begin
                hit_sat = 1'b1;
                hit_idx = IDX_W'(e);
            end
        end
    end

    always_comb begin
        learn_found = 1'b0;
        learn_idx   = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (learn_match[e]) begin
                learn_found = 1'b1;
                learn_idx   = IDX_W'(e);
            end
        end
    end

    // update selection: a learning event in the same cycle drops feedback
    always_comb begin
        if (learn_en)                  op = TBL_LEARN;
        else if (fb_en && last_vld_q)  op = TBL_FB;
        else                           op = TBL_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) begin
                sig_mem[e]  <= '0;
                conf_mem[e] <= '0;
            end
            vld_q      <= '0;
            rr_q       <= '0;
            last_idx_q <= '0;
            last_vld_q <= 1'b0;
        end else begin
            unique case (op)
                TBL_LEARN: begin
                    if (learn_found) begin
                        if (conf_mem[learn_idx] != CONF_MAX)
                            conf_mem[learn_idx] <= conf_mem[learn_idx] + 1'b1;
                    end else begin
                        sig_mem[rr_q]  <= learn_sig;
                        conf_mem[rr_q] <= CONF_INIT;
                        vld_q[rr_q]    <= 1'b1;
                        rr_q           <= (rr_q == LAST_IDX) ? '0 : rr_q + 1'b1;
                    end
                end
                TBL_FB: begin
                    if (fb_correct) begin
                        if (conf_mem[last_idx_q] != CONF_MAX)
                            conf_mem[last_idx_q] <= conf_mem[last_idx_q] + 1'b1;
                    end else begin
                        if (conf_mem[last_idx_q] != '0)
                            conf_mem[last_idx_q] <= conf_mem[last_idx_q] - 1'b1;
                    end
                    last_vld_q <= 1'b0;
                end
                TBL_IDLE: ;
                default: ;
            endcase
            if (issue_en) begin
                last_idx_q <= hit_idx;
                last_vld_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/lt_predictor.sv
module lt_predictor #(
    parameter int NUM_BLOCKS = 8,
    parameter int PC_W       = 30,
    parameter int SIG_W      = 13,
    parameter int ENTRIES    = 4,
    parameter int CONF_W     = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          acc_valid,
    input  logic [$clog2(NUM_BLOCKS)-1:0] acc_block,
    input  logic [PC_W-1:0]               acc_pc,
    input  logic                          acc_miss,
    input  logic                          acc_shared,
    input  logic                          inv_valid,
    input  logic [$clog2(NUM_BLOCKS)-1:0] inv_block,
    input  logic                          fb_valid,
    input  logic [$clog2(NUM_BLOCKS)-1:0] fb_block,
    input  logic                          fb_correct,
    output logic                          selfinv_valid,
    output logic [$clog2(NUM_BLOCKS)-1:0] selfinv_block
);

    localparam int BLK_W = $clog2(NUM_BLOCKS);
    localparam int IDX_W = $clog2(ENTRIES);

    logic [NUM_BLOCKS-1:0] issue_vec;

    for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
        logic             inv_hit, acc_hit, miss_ev, touch_ev, close_ev;
        logic             is_open, hit_sat, fb_hit;
        logic [SIG_W-1:0] sig_q, sig_upd;
        logic [IDX_W-1:0] hit_idx;

        // an invalidation to the same block wins over a same-cycle access
        assign inv_hit  = inv_valid && (inv_block == BLK_W'(b));
        assign acc_hit  = acc_valid && acc_shared && (acc_block == BLK_W'(b)) && !inv_hit;
        assign miss_ev  = acc_hit && acc_miss;
        assign touch_ev = acc_hit && !acc_miss && is_open;
        assign fb_hit   = fb_valid && (fb_block == BLK_W'(b));
        assign issue_vec[b] = touch_ev && hit_sat;
        assign close_ev = inv_hit || issue_vec[b];

        ltp_trace #(
            .PC_W  (PC_W),
            .SIG_W (SIG_W)
        ) i_trace (
            .clk      (clk),
            .rst_n    (rst_n),
            .ev_miss  (miss_ev),
            .ev_touch (touch_ev),
            .ev_close (close_ev),
            .pc       (acc_pc),
            .is_open  (is_open),
            .sig_q    (sig_q),
            .sig_upd  (sig_upd)
        );

        ltp_sig_table #(
            .SIG_W   (SIG_W),
            .ENTRIES (ENTRIES),
            .CONF_W  (CONF_W)
        ) i_table (
            .clk        (clk),
            .rst_n      (rst_n),
            .probe_sig  (sig_upd),
            .learn_en   (inv_hit && is_open),
            .learn_sig  (sig_q),
            .fb_en      (fb_hit),
            .fb_correct (fb_correct),
            .issue_en   (issue_vec[b]),
            .hit_sat    (hit_sat),
            .hit_idx    (hit_idx)
        );
    end

    // registered request: one access per cycle, so at most one block issues
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            selfinv_valid <= 1'b0;
            selfinv_block <= '0;
        end else begin
            selfinv_valid <= |issue_vec;
            selfinv_block <= (|issue_vec) ? acc_block : '0;
        end
    end

endmodule

// File: rtl/lt_predictor_chk.sv
module lt_predictor_chk #(
    parameter int BLK_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             acc_valid,
    input logic             acc_miss,
    input logic             acc_shared,
    input logic [BLK_W-1:0] acc_block,
    input logic             selfinv_valid,
    input logic [BLK_W-1:0] selfinv_block
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !selfinv_valid);

    // R2
    miss_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_miss) |=> !selfinv_valid);

    // R7
    unshared_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_shared) |=> !selfinv_valid);

    // R6
    req_follows_touch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        selfinv_valid |-> $past(acc_valid && acc_shared && !acc_miss));

    // R6
    req_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        selfinv_valid |-> (selfinv_block == $past(acc_block)));

endmodule

bind lt_predictor lt_predictor_chk #(.BLK_W(BLK_W)) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .acc_valid     (acc_valid),
    .acc_miss      (acc_miss),
    .acc_shared    (acc_shared),
    .acc_block     (acc_block),
    .selfinv_valid (selfinv_valid),
    .selfinv_block (selfinv_block)
);

// File: tb/test_lt_predictor.sv
`timescale 1ns/1ps
module test_lt_predictor;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [2:0]  acc_block = '0;
    logic [29:0] acc_pc = '0;
    logic        acc_miss = 1'b0;
    logic        acc_shared = 1'b0;
    logic        inv_valid = 1'b0;
    logic [2:0]  inv_block = '0;
    logic        fb_valid = 1'b0;
    logic [2:0]  fb_block = '0;
    logic        fb_correct = 1'b0;
    logic        selfinv_valid;
    logic [2:0]  selfinv_block;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    lt_predictor i_lt_predictor (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_block(acc_block), .acc_pc(acc_pc),
        .acc_miss(acc_miss), .acc_shared(acc_shared),
        .inv_valid(inv_valid), .inv_block(inv_block),
        .fb_valid(fb_valid), .fb_block(fb_block), .fb_correct(fb_correct),
        .selfinv_valid(selfinv_valid), .selfinv_block(selfinv_block)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one access; returns the output sampled in the following cycle
    task automatic access(input int blk, input logic [29:0] pc, input bit miss,
                          input bit shared, output bit pulse, output int pblk);
        @(negedge clk);
        acc_valid = 1'b1; acc_block = 3'(blk); acc_pc = pc;
        acc_miss = miss; acc_shared = shared;
        @(posedge clk); #1;
        pulse = selfinv_valid; pblk = int'(selfinv_block);
        acc_valid = 1'b0; acc_miss = 1'b0; acc_shared = 1'b0;
    endtask

    task automatic invalidate(input int blk);
        @(negedge clk);
        inv_valid = 1'b1; inv_block = 3'(blk);
        @(negedge clk);
        inv_valid = 1'b0;
    endtask

    task automatic feedback(input int blk, input bit correct);
        @(negedge clk);
        fb_valid = 1'b1; fb_block = 3'(blk); fb_correct = correct;
        @(negedge clk);
        fb_valid = 1'b0;
    endtask

    // miss with p0, then n-1 touches; reports pulses before the last and the last one
    task automatic trace(input int blk, input int n, input logic [29:0] p0,
                         input logic [29:0] p1, input logic [29:0] p2,
                         output int early, output bit last, output int lblk);
        bit p; int pb;
        early = 0;
        access(blk, p0, 1'b1, 1'b1, p, pb);
        if (p) early++;
        if (n == 2) begin
            access(blk, p1, 1'b0, 1'b1, last, lblk);
        end else begin
            access(blk, p1, 1'b0, 1'b1, p, pb);
            if (p) early++;
            access(blk, p2, 1'b0, 1'b1, last, lblk);
        end
    endtask

    localparam logic [29:0] PA = 30'h0001_0100;
    localparam logic [29:0] PB = 30'h0000_0230;
    localparam logic [29:0] PC = 30'h0000_0045;

    task automatic t_reset();
        bit p; int pb;
        chk(selfinv_valid == 1'b0, "R1 idle after reset", selfinv_valid, 0);
        access(0, PA, 1'b0, 1'b1, p, pb);
        chk(p == 1'b0, "R1 touch with no trace", p, 0);
    endtask

    task automatic t_learn();
        int e; bit l; int lb;
        trace(2, 3, PA, PB, PC, e, l, lb);
        chk(l == 1'b0, "R5 empty table silent", l, 0);
        invalidate(2);
        trace(2, 3, PA, PB, PC, e, l, lb);
        chk(l == 1'b0, "R4 first learn at confidence 2", l, 0);
        invalidate(2);
        trace(2, 3, PA, PB, PC, e, l, lb);
        chk(e == 0, "R2 miss and partial trace silent", e, 0);
        chk(l == 1'b1, "R5 saturated match fires", l, 1);
        chk(lb == 2, "R6 request block index", lb, 2);
        @(posedge clk); #1;
        chk(selfinv_valid == 1'b0, "R6 one-cycle pulse", selfinv_valid, 0);
    endtask

    task automatic t_closed();
        bit p; int pb;
        access(2, 30'h0, 1'b0, 1'b1, p, pb);
        chk(p == 1'b0, "R7 touch after request ignored", p, 0);
    endtask

    task automatic t_feedback();
        int e; bit l; int lb;
        feedback(2, 1'b0);
        trace(2, 3, PA, PB, PC, e, l, lb);
        chk(l == 1'b0, "R8 premature lowers confidence", l, 0);
        invalidate(2);
        trace(2, 3, PA, PB, PC, e, l, lb);
        chk(l == 1'b1, "R8 relearned fires", l, 1);
        feedback(2, 1'b1);
        trace(2, 3, PA, PB, PC, e, l, lb);
        chk(l == 1'b1, "R8 correct keeps saturation", l, 1);
        feedback(2, 1'b0);
        feedback(2, 1'b0);
        trace(2, 3, PA, PB, PC, e, l, lb);
        chk(l == 1'b0, "R8 one step down", l, 0);
        invalidate(2);
        trace(2, 3, PA, PB, PC, e, l, lb);
        chk(l == 1'b1, "R8 second feedback ignored", l, 1);
    endtask

    task automatic t_wrap();
        int e; bit l; int lb;
        for (int k = 0; k < 2; k++) begin
            trace(3, 2, 30'h0000_1FFF, 30'h0000_0002, 30'h0, e, l, lb);
            invalidate(3);
        end
        trace(3, 2, 30'h3FFF_E000, 30'h0000_0001, 30'h0, e, l, lb);
        chk(l == 1'b1, "R3 truncated sum matches", l, 1);
        chk(lb == 3, "R3 request block index", lb, 3);
    endtask

    task automatic t_unshared();
        int e; bit l; int lb; bit p; int pb;
        for (int k = 0; k < 2; k++) begin
            trace(4, 2, PA, PB, 30'h0, e, l, lb);
            invalidate(4);
        end
        access(4, PA, 1'b1, 1'b1, p, pb);
        access(4, 30'h0000_0777, 1'b0, 1'b0, p, pb);
        chk(p == 1'b0, "R7 unshared access silent", p, 0);
        access(4, PB, 1'b0, 1'b1, l, lb);
        chk(l == 1'b1, "R7 unshared access left signature", l, 1);
    endtask

    task automatic t_isolation();
        int e; bit l; int lb;
        trace(5, 3, PA, PB, PC, e, l, lb);
        chk(l == 1'b0, "R5 other block pattern not shared", l, 0);
    endtask

    task automatic t_replace();
        int e; bit l; int lb;
        localparam logic [29:0] Q = 30'h0000_0010;
        for (int k = 0; k < 2; k++) begin
            trace(6, 2, 30'h100, Q, 30'h0, e, l, lb);
            invalidate(6);
        end
        trace(6, 2, 30'h100, Q, 30'h0, e, l, lb);
        chk(l == 1'b1, "R9 first pattern fires", l, 1);
        for (int k = 1; k <= 4; k++) begin
            trace(6, 2, 30'(32'h100 + 32'h40 * k), Q, 30'h0, e, l, lb);
            invalidate(6);
        end
        trace(6, 2, 30'h100, Q, 30'h0, e, l, lb);
        chk(l == 1'b0, "R9 oldest entry replaced", l, 0);
        trace(6, 2, 30'h140, Q, 30'h0, e, l, lb);
        invalidate(6);
        trace(6, 2, 30'h140, Q, 30'h0, e, l, lb);
        chk(l == 1'b1, "R9 second entry kept", l, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_learn();
        t_closed();
        t_feedback();
        t_wrap();
        t_unshared();
        t_isolation();
        t_replace();
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule